// File: doc/BRIEF.md
# Multiplexed Bus Cycle Strobe Generator

This block produces the byte-lane, bus-size, transceiver-enable and direction strobes for a 16-bit controller that shares address and data on one set of pins. A bus cycle moves through four phases, T1 to T4. The address sits on the shared bus in T1, and data moves in the later phases. Each request carries the cycle kind, the low address bit, the transfer size and the width of the external device. The block checks the request and latches it. It then holds the matching strobe pattern for the whole cycle.

The two byte-lane pins (an active-low high-byte enable and the low address bit) select the upper byte, the lower byte or both bytes. A fourth combination marks a DRAM refresh cycle. For a refresh cycle the block drives the shared bus only in T1 and never opens the data transceiver. The bus-hold and reset flags three-state the high-byte enable and the transceiver enable. Those pins are modelled with pullups, so a pin whose enable is low reads as logic 1. Address latching, wait states, bus arbitration and DMA are handled by other blocks.

States: IDLE (code 0), T1 (1), T2 (2), T3 (3), T4 (4).
Transitions:
- IDLE→T1: a legal request is accepted.
- IDLE→IDLE: no request, or the request is rejected, or hold is active.
- T1→T2, T2→T3 and T3→T4: these always happen.
- T4→T1: a legal request is accepted back to back.
- T4→IDLE: there is no request, or it is rejected.

Top module: `mux_bus_strobe_gen`

## Requirements
- R1: While rst_n is low, bhe_oe_o, ad_oe_o and den_oe_o are 0, bhe_n_o, ad0_o and den_n_o read 1 (pullup), bsize8_o and dtr_o are 0, and after reset phase_o is 0 (IDLE).
- R2: A request is sampled on a rising edge only in IDLE or T4. A legal request that is sampled moves phase_o to 1 (T1) on that edge, then through 2, 3 and 4 on the next three edges, and then to IDLE or straight to T1 if another legal request is sampled in T4. Request kinds are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write and 4 refresh.
- R3: From T1 to T4, (bhe_n_o, ad0_o in T1) is 00 for a word, 01 for a high byte (byte request with address bit 0 = 1), 10 for a low byte (byte request with address bit 0 = 0) and 11 for refresh. bhe_n_o holds its value from T1 to T4 and is driven 1 in IDLE.
- R4: ad_oe_o is 1 in T1 of every cycle. In T2 to T4 it is 1 only for kinds 1 and 3 (writes). For reads and refresh the shared bus is three-stated there, and ad0_o reads 1.
- R5: bsize8_o is 1 from T1 to T4 when the accepted request had the 8-bit flag set, and 0 otherwise, including in IDLE.
- R6: den_n_o is 0 only in T2 and T3 of memory and I/O cycles. It is 1 in IDLE, T1 and T4, and throughout a refresh cycle.
- R7: dtr_o becomes 1 for a write and 0 for a read on the edge that enters T1. A refresh leaves it unchanged. In any cycle where dtr_o differs from its previous value, den_n_o is 1.
- R8: While hold_i is 1, bhe_oe_o and den_oe_o are 0, bhe_n_o and den_n_o read 1, and no request is accepted or flagged.
- R9: A word request with address bit 0 = 1, or a kind code 5 to 7, starts no cycle. Instead req_err_o is 1 for the one cycle after the sampling edge.
- R10: Requests that arrive in T1, T2 or T3 are ignored. They do not change the running cycle and do not raise req_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset flag |
| hold_i | input | 1 | Bus-hold flag |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | KIND_W | Cycle kind code |
| req_a0_i | input | 1 | Address bit 0 |
| req_word_i | input | 1 | 1 = word, 0 = byte |
| req_bus8_i | input | 1 | 1 = 8-bit device |
| phase_o | output | 3 | Current phase code |
| req_err_o | output | 1 | Rejected-request pulse |
| bhe_n_o | output | 1 | High-byte enable, active low |
| bhe_oe_o | output | 1 | Drive enable for bhe_n_o |
| ad0_o | output | 1 | Shared-bus bit 0 |
| ad_oe_o | output | 1 | Shared-bus drive enable |
| bsize8_o | output | 1 | 8-bit cycle flag |
| den_n_o | output | 1 | Transceiver enable, active low |
| den_oe_o | output | 1 | Drive enable for den_n_o |
| dtr_o | output | 1 | Direction, 1 = transmit |

## Verification
The hardest situation to reach is a direction reversal with no idle cycle between two cycles. Getting there needs a read request presented during T4 of a write, so that dtr_o flips on the same edge that enters T1. The bench counts edges from the start of the write and drives the second request in the half-cycle before the T4→T1 edge. It then checks that the transceiver enable stays off across the flip and opens in the read's T2. A second hard-to-reach case is a request that arrives during T2, which must leave the running cycle untouched.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    localparam int KIND_W = 3;

    localparam logic [KIND_W-1:0] KD_MEM_RD  = KIND_W'(0);
    localparam logic [KIND_W-1:0] KD_MEM_WR  = KIND_W'(1);
    localparam logic [KIND_W-1:0] KD_IO_RD   = KIND_W'(2);
    localparam logic [KIND_W-1:0] KD_IO_WR   = KIND_W'(3);
    localparam logic [KIND_W-1:0] KD_REFRESH = KIND_W'(4);

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4
    } phase_e;

    typedef struct packed {
        logic bhe_n;
        logic ad0;
        logic legal;
        logic refresh;
        logic write;
    } lane_t;
endpackage

// File: rtl/mbs_lane_enc.sv
module mbs_lane_enc
    import mbs_pkg::*;
#(
    parameter int KW = 3
) (
    input  logic [KW-1:0] kind,
    input  logic          a0,
    input  logic          word,
    output lane_t         lane
);
    always_comb begin
        lane = '{bhe_n: 1'b1, ad0: 1'b1, legal: 1'b0, refresh: 1'b0, write: 1'b0};
        case (kind)
            KW'(KD_REFRESH): begin
                lane.legal   = 1'b1;
                lane.refresh = 1'b1;
            end
            KW'(KD_MEM_RD), KW'(KD_MEM_WR), KW'(KD_IO_RD), KW'(KD_IO_WR): begin
                lane.write = kind[0];
                if (word) begin
                    lane.legal = !a0;
                    lane.bhe_n = 1'b0;
                    lane.ad0   = 1'b0;
                end else begin
                    lane.legal = 1'b1;
                    lane.bhe_n = !a0;
                    lane.ad0   = a0;
                end
            end
            default: lane.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/mbs_phase_seq.sv
module mbs_phase_seq
    import mbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hold,
    input  logic   req_valid,
    input  logic   req_legal,
    output phase_e phase,
    output logic   start,
    output logic   err
);
    phase_e phase_nx;
    logic   can_take;

    assign can_take = (phase == PH_IDLE || phase == PH_T4) && req_valid && !hold;
    assign start    = can_take && req_legal;

    always_comb begin
        unique case (phase)
            PH_IDLE: phase_nx = start ? PH_T1 : PH_IDLE;
            PH_T1:   phase_nx = PH_T2;
            PH_T2:   phase_nx = PH_T3;
            PH_T3:   phase_nx = PH_T4;
            PH_T4:   phase_nx = start ? PH_T1 : PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            err   <= 1'b0;
        end else begin
            phase <= phase_nx;
            err   <= can_take && !req_legal;
        end
    end

    AST_T1_TO_T2: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_T1 |=> phase == PH_T2); // R2
    AST_T2_TO_T3: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_T2 |=> phase == PH_T3); // R2
    AST_T3_TO_T4: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_T3 |=> phase == PH_T4); // R2
    AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> phase != PH_T1); // R9
    AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase inside {PH_T1, PH_T2, PH_T3}) |=> !err); // R10
endmodule

// File: rtl/mbs_den_ctl.sv
module mbs_den_ctl
    import mbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   req_write,
    input  logic   req_refresh,
    input  phase_e phase,
    input  logic   cyc_refresh,
    output logic   dtr,
    output logic   den_n
);
    logic dtr_prev;
    logic dir_flip;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dtr      <= 1'b0;
            dtr_prev <= 1'b0;
        end else begin
            dtr_prev <= dtr;
            if (start && !req_refresh) dtr <= req_write;
        end
    end

    assign dir_flip = dtr != dtr_prev;

    always_comb begin
        den_n = 1'b1;
        if ((phase == PH_T2 || phase == PH_T3) && !cyc_refresh && !dir_flip)
            den_n = 1'b0;
    end

    AST_DTR_MOVES_AT_T1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dtr) |-> phase == PH_T1); // R7
    AST_DEN_OFF_ON_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dtr) |-> den_n); // R7
endmodule

// File: rtl/mux_bus_strobe_gen.sv
module mux_bus_strobe_gen
    import mbs_pkg::*;
#(
    parameter int KIND_W = mbs_pkg::KIND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              req_valid_i,
    input  logic [KIND_W-1:0] req_kind_i,
    input  logic              req_a0_i,
    input  logic              req_word_i,
    input  logic              req_bus8_i,
    output logic [2:0]        phase_o,
    output logic              req_err_o,
    output logic              bhe_n_o,
    output logic              bhe_oe_o,
    output logic              ad0_o,
    output logic              ad_oe_o,
    output logic              bsize8_o,
    output logic              den_n_o,
    output logic              den_oe_o,
    output logic              dtr_o
);
    lane_t  lane_in;
    lane_t  cyc_q;
    logic   bus8_q;
    phase_e phase;
    logic   start;
    logic   den_int;
    logic   dtr_int;
    logic   in_cycle;

    mbs_lane_enc #(.KW(KIND_W)) u_enc (
        .kind (req_kind_i),
        .a0   (req_a0_i),
        .word (req_word_i),
        .lane (lane_in)
    );

    mbs_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold_i),
        .req_valid (req_valid_i),
        .req_legal (lane_in.legal),
        .phase     (phase),
        .start     (start),
        .err       (req_err_o)
    );

    mbs_den_ctl u_den (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .req_write   (lane_in.write),
        .req_refresh (lane_in.refresh),
        .phase       (phase),
        .cyc_refresh (cyc_q.refresh),
        .dtr         (dtr_int),
        .den_n       (den_int)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= '{bhe_n: 1'b1, ad0: 1'b1, legal: 1'b0, refresh: 1'b0, write: 1'b0};
            bus8_q <= 1'b0;
        end else if (start) begin
            cyc_q  <= lane_in;
            bus8_q <= req_bus8_i;
        end
    end

    assign in_cycle = phase != PH_IDLE;
    assign phase_o  = phase;

    always_comb begin
        bhe_oe_o = 1'b0;
        bhe_n_o  = 1'b1;
        ad_oe_o  = 1'b0;
        ad0_o    = 1'b1;
        den_oe_o = 1'b0;
        den_n_o  = 1'b1;
        bsize8_o = 1'b0;
        dtr_o    = 1'b0;
        if (rst_n) begin
            dtr_o    = dtr_int;
            bsize8_o = in_cycle && bus8_q;
            ad_oe_o  = (phase == PH_T1) ||
                       ((phase inside {PH_T2, PH_T3, PH_T4}) && cyc_q.write);
            ad0_o    = ad_oe_o ? cyc_q.ad0 : 1'b1;
            if (!hold_i) begin
                bhe_oe_o = 1'b1;
                bhe_n_o  = in_cycle ? cyc_q.bhe_n : 1'b1;
                den_oe_o = 1'b1;
                den_n_o  = den_int;
            end
        end
    end

    AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> (!bhe_oe_o && !den_oe_o && bhe_n_o && den_n_o)); // R8
    AST_LANE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase inside {PH_T2, PH_T3, PH_T4}) && !hold_i && !$past(hold_i))
        |-> $stable(bhe_n_o)); // R3
    AST_REFRESH_NO_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cycle && cyc_q.refresh) |-> den_n_o); // R6
    AST_REFRESH_AD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase inside {PH_T2, PH_T3, PH_T4}) && cyc_q.refresh) |-> !ad_oe_o); // R4
    AST_BSIZE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd0) |-> !bsize8_o); // R5
endmodule

// File: tb/tb_mux_bus_strobe_gen.sv
module tb_mux_bus_strobe_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_i = 1'b0;
    logic req_valid_i = 1'b0;
    logic [2:0] req_kind_i = 3'd0;
    logic req_a0_i = 1'b0;
    logic req_word_i = 1'b0;
    logic req_bus8_i = 1'b0;
    logic [2:0] phase_o;
    logic req_err_o, bhe_n_o, bhe_oe_o, ad0_o, ad_oe_o, bsize8_o;
    logic den_n_o, den_oe_o, dtr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mux_bus_strobe_gen dut (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .req_valid_i(req_valid_i),
        .req_kind_i(req_kind_i), .req_a0_i(req_a0_i), .req_word_i(req_word_i),
        .req_bus8_i(req_bus8_i), .phase_o(phase_o), .req_err_o(req_err_o),
        .bhe_n_o(bhe_n_o), .bhe_oe_o(bhe_oe_o), .ad0_o(ad0_o), .ad_oe_o(ad_oe_o),
        .bsize8_o(bsize8_o), .den_n_o(den_n_o), .den_oe_o(den_oe_o), .dtr_o(dtr_o)
    );

    task automatic chk(string rq, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic drive_req(logic [2:0] kind, logic a0, logic word, logic bus8);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_kind_i  = kind;
        req_a0_i    = a0;
        req_word_i  = word;
        req_bus8_i  = bus8;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    // Checks the phases T1..T4 of one cycle, starting at the T1 sample point.
    task automatic check_phases(logic [2:0] kind, logic bus8, int ebhe, int ead0, string tag);
        bit wr  = (kind == 3'd1 || kind == 3'd3);
        bit ref_c = (kind == 3'd4);
        for (int ph = 1; ph <= 4; ph++) begin
            chk("R2", {tag, " phase"}, phase_o, ph);
            chk("R3", {tag, " bhe_n"}, bhe_n_o, ebhe);
            chk("R4", {tag, " ad_oe"}, ad_oe_o, (ph == 1 || wr) ? 1 : 0);
            if (ph == 1) chk("R3", {tag, " ad0"}, ad0_o, ead0);
            else if (!wr) chk("R4", {tag, " ad0 pull"}, ad0_o, 1);
            chk("R5", {tag, " bsize8"}, bsize8_o, bus8);
            chk("R6", {tag, " den_n"}, den_n_o, ((ph == 2 || ph == 3) && !ref_c) ? 0 : 1);
            if (ph < 4) @(negedge clk);
        end
    endtask

    task automatic run_cycle(logic [2:0] kind, logic a0, logic word, logic bus8,
                             int ebhe, int ead0, string tag);
        drive_req(kind, a0, word, bus8);
        check_phases(kind, bus8, ebhe, ead0, tag);
        @(negedge clk);
        chk("R2", {tag, " back to idle"}, phase_o, 0);
        chk("R5", {tag, " bsize8 idle"}, bsize8_o, 0);
        chk("R3", {tag, " bhe_n idle"}, bhe_n_o, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "bhe_oe", bhe_oe_o, 0);
        chk("R1", "den_oe", den_oe_o, 0);
        chk("R1", "ad_oe", ad_oe_o, 0);
        chk("R1", "pins pulled", {29'd0, bhe_n_o, den_n_o, ad0_o}, 7);
        chk("R1", "bsize8/dtr", {30'd0, bsize8_o, dtr_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "phase after reset", phase_o, 0);
        chk("R1", "bhe_oe after reset", bhe_oe_o, 1);
    endtask

    task automatic t_lanes();
        run_cycle(3'd0, 1'b0, 1'b1, 1'b0, 0, 0, "word rd");
        chk("R7", "dtr after read", dtr_o, 0);
        run_cycle(3'd1, 1'b0, 1'b0, 1'b0, 1, 0, "low byte wr");
        chk("R7", "dtr after write", dtr_o, 1);
        run_cycle(3'd2, 1'b1, 1'b0, 1'b1, 0, 1, "high byte io rd bus8");
        chk("R7", "dtr after io read", dtr_o, 0);
        run_cycle(3'd3, 1'b0, 1'b1, 1'b1, 0, 0, "word io wr bus8");
        run_cycle(3'd4, 1'b0, 1'b0, 1'b0, 1, 1, "refresh");
        chk("R7", "dtr kept by refresh", dtr_o, 1);
    endtask

    task automatic t_back_to_back();
        drive_req(3'd1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R2", "b2b write T4", phase_o, 4);
        chk("R7", "b2b dtr write", dtr_o, 1);
        req_valid_i = 1'b1;
        req_kind_i  = 3'd0;
        req_a0_i    = 1'b1;
        req_word_i  = 1'b0;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk("R2", "b2b read T1", phase_o, 1);
        chk("R7", "b2b dtr flipped", dtr_o, 0);
        chk("R7", "b2b den off at flip", den_n_o, 1);
        chk("R3", "b2b high byte", {30'd0, bhe_n_o, ad0_o}, 1);
        @(negedge clk);
        chk("R6", "b2b den on in T2", den_n_o, 0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R2", "b2b idle", phase_o, 0);
    endtask

    task automatic t_busy_ignore();
        drive_req(3'd2, 1'b0, 1'b0, 1'b0);
        req_valid_i = 1'b1;
        req_kind_i  = 3'd1;
        req_word_i  = 1'b1;
        req_a0_i    = 1'b1;
        @(negedge clk);
        chk("R10", "busy phase", phase_o, 2);
        chk("R10", "busy no err", req_err_o, 0);
        req_valid_i = 1'b0;
        @(negedge clk);
        chk("R10", "busy lane kept", bhe_n_o, 1);
        chk("R10", "busy dtr kept", dtr_o, 0);
        @(negedge clk);
        @(negedge clk);
        chk("R10", "busy to idle", phase_o, 0);
    endtask

    task automatic t_reject();
        drive_req(3'd0, 1'b1, 1'b1, 1'b0);
        chk("R9", "odd word no start", phase_o, 0);
        chk("R9", "odd word err", req_err_o, 1);
        @(negedge clk);
        chk("R9", "err one cycle", req_err_o, 0);
        drive_req(3'd6, 1'b0, 1'b0, 1'b0);
        chk("R9", "bad kind no start", phase_o, 0);
        chk("R9", "bad kind err", req_err_o, 1);
        @(negedge clk);
    endtask

    task automatic t_hold();
        @(negedge clk);
        hold_i = 1'b1;
        #1;
        chk("R8", "hold oe", {30'd0, bhe_oe_o, den_oe_o}, 0);
        chk("R8", "hold pulled", {30'd0, bhe_n_o, den_n_o}, 3);
        drive_req(3'd0, 1'b0, 1'b1, 1'b0);
        chk("R8", "hold no start", phase_o, 0);
        chk("R8", "hold no err", req_err_o, 0);
        hold_i = 1'b0;
        @(negedge clk);
        chk("R8", "hold release oe", {30'd0, bhe_oe_o, den_oe_o}, 3);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_lanes();
        t_back_to_back();
        t_busy_ignore();
        t_reject();
        t_hold();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule